// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counting timer. It advances on a `tick` input that stands for the instruction clock, which runs at one quarter of the system clock. Each tick first passes a prescaler with three ratios: 1, 4 or 16. The counter is compared with a period register. When the two are equal on an advancing step, the counter returns to zero and a one-clock match pulse is sent out. Other logic, such as a pulse-width generator or a serial shift clock, can use this pulse as its time base.

A programmable postscaler divides the match events by any ratio from 1 to 16. When it reaches its terminal count it sets a sticky interrupt flag. Software clears the flag through a dedicated clear input. The interrupt output is asserted only while the flag is set and the enable input is high.

Software reaches the control, counter and period registers through a simple write port and a combinational read port. Writing the counter or the control register restarts both scalers.

Top module: `period_timer`

## Requirements
- R1: After reset the control reads 0x00, the counter reads 0x00, the period reads 0xFF, and `irq_flag`, `irq` and `match_pulse` are low.
- R2: Control bits [1:0] select the prescale ratio: 00 gives 1, 01 gives 4, and 10 or 11 give 16. The counter advances once per that many ticks.
- R3: On an advancing step where the counter equals the period, the counter goes to 0 and `match_pulse` is high for the following clock. Otherwise the step increments the counter. A period of 0 gives one match per prescaled step.
- R4: Control bits [6:3] hold N. The flag is set by every (N+1)-th match counted since the postscaler was last cleared.
- R5: `irq_flag` stays set until `flag_clr` is high at a clock edge. If a postscaled match and `flag_clr` occur in the same cycle, the flag stays set.
- R6: `irq` is high exactly when `irq_flag` and `irq_en` are both high.
- R7: While control bit 2 (run) is 0, ticks are ignored. The counter, prescaler and postscaler hold their values, and no match pulse is produced.
- R8: A write to the counter (address 1) or to the control register (address 0) clears the prescaler and postscaler counts. A tick in the cycle of such a write is dropped, so the written counter value holds.
- R9: A write to the period register (address 2) leaves the counter value unchanged.
- R10: Control bit 7 always reads 0. Read address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-clock enable, one quarter of the system clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 counter, 2 period |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes; 3 reads zero |
| rd_data | output | 8 | Combinational read data |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| match_pulse | output | 1 | Unscaled one-clock match pulse |
| irq_flag | output | 1 | Sticky postscaled interrupt flag |
| irq | output | 1 | Flag gated by enable |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and bus, a 4-bit postscaler, and a three-stage prescaler that steps by powers of four. These values make every ratio reachable, from 1:1 through 1:16 on the prescaler and 1:1 through 1:16 on the postscaler. They also reach the period extremes of 0, where every prescaled step matches, and 0xFF at reset. Table vectors mix prescale, postscale and period settings and check the match count and flag state against closed-form tick arithmetic. Directed tests then cover the scaler restart on writes, a write colliding with a tick, and a flag set colliding with a flag clear.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_COUNT  = 2'd1,
      REG_PERIOD = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

   // Clamp a prescale select code to the last implemented stage.
   function automatic int clamp_stage(input int code, input int stages);
      return (code >= stages - 1) ? stages - 1 : code;
   endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
   parameter int STEP_LOG = 2,
   parameter int STAGES   = 3,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [SEL_W-1:0] sel,
   output logic             fire
);
   import ptmr_pkg::*;

   localparam int CW = STEP_LOG * (STAGES - 1);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("ptmr_prescale: STAGES must be at least 1");
      end
      if (STEP_LOG < 0) begin : g_bad_step
         $error("ptmr_prescale: STEP_LOG must not be negative");
      end

      if (CW == 0) begin : g_bypass
         logic unused_in;
         assign unused_in = ^{sel, clr, clk, rst_n};
         assign fire = adv;
      end else begin : g_div
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] lim;

         always_comb begin
            int k;
            k   = clamp_stage(int'(sel), STAGES);
            lim = CW'((1 << (STEP_LOG * k)) - 1);
         end

         assign fire = adv && (cnt_q == lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr) begin
               cnt_q <= '0;
            end else if (adv) begin
               cnt_q <= fire ? '0 : cnt_q + 1'b1;
            end
         end

         AST_PRE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= lim); // R2
         AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt_q == '0)); // R8
      end
   endgenerate

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic [W-1:0] period,
   output logic [W-1:0] value,
   output logic         hit
);
   generate
      if (W < 2) begin : g_bad_w
         $error("ptmr_count: W must be at least 2");
      end
   endgenerate

   assign hit = step && !load && (value == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (load) begin
         value <= load_val;
      end else if (step) begin
         value <= (value == period) ? '0 : value + 1'b1;
      end
   end

   AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (value == '0)); // R3
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (value == $past(load_val))); // R8

endmodule

// File: rtl/ptmr_postscale.sv
module ptmr_postscale #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         evt,
   input  logic [W-1:0] ratio_m1,
   output logic         done
);
   generate
      if (W < 1) begin : g_bad_w
         $error("ptmr_postscale: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign done = evt && (cnt_q == ratio_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (evt) begin
         cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
   end

   AST_POST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ratio_m1); // R4
   AST_POST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/period_timer.sv
module period_timer #(
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 8,
   parameter int POST_W       = 4,
   parameter int PRE_SEL_W    = 2,
   parameter int PRE_STEP_LOG = 2,
   parameter int PRE_STAGES   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              flag_clr,
   input  logic              irq_en,
   output logic              match_pulse,
   output logic              irq_flag,
   output logic              irq
);
   import ptmr_pkg::*;

   localparam int ON_BIT    = PRE_SEL_W;
   localparam int POST_LSB  = PRE_SEL_W + 1;
   localparam int CTRL_USED = POST_LSB + POST_W;

   generate
      if (CTRL_USED > DATA_W) begin : g_bad_ctrl
         $error("period_timer: control fields exceed DATA_W");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("period_timer: CNT_W exceeds DATA_W");
      end
      if (CNT_W < DATA_W) begin : g_narrow
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:CNT_W];
      end
   endgenerate

   // control register fields
   logic [PRE_SEL_W-1:0] pre_q;
   logic                 on_q;
   logic [POST_W-1:0]    post_q;
   logic [CNT_W-1:0]     period_q;

   logic wr_ctrl, wr_cnt, wr_per;
   assign wr_ctrl = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
   assign wr_cnt  = wr_en && (reg_sel_e'(wr_addr) == REG_COUNT);
   assign wr_per  = wr_en && (reg_sel_e'(wr_addr) == REG_PERIOD);

   logic clr_scalers;
   assign clr_scalers = wr_ctrl || wr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         on_q   <= 1'b0;
         post_q <= '0;
      end else if (wr_ctrl) begin
         pre_q  <= wr_data[PRE_SEL_W-1:0];
         on_q   <= wr_data[ON_BIT];
         post_q <= wr_data[POST_LSB +: POST_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '1;
      end else if (wr_per) begin
         period_q <= wr_data[CNT_W-1:0];
      end
   end

   // datapath
   logic adv, step, hit, post_done;
   logic [CNT_W-1:0] count;

   assign adv = tick && on_q && !clr_scalers;

   ptmr_prescale #(
      .STEP_LOG(PRE_STEP_LOG),
      .STAGES  (PRE_STAGES),
      .SEL_W   (PRE_SEL_W)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_scalers),
      .adv  (adv),
      .sel  (pre_q),
      .fire (step)
   );

   ptmr_count #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_cnt),
      .load_val(wr_data[CNT_W-1:0]),
      .step    (step),
      .period  (period_q),
      .value   (count),
      .hit     (hit)
   );

   ptmr_postscale #(.W(POST_W)) u_post (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_scalers),
      .evt     (hit),
      .ratio_m1(post_q),
      .done    (post_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
      end else begin
         match_pulse <= hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag <= 1'b0;
      end else if (post_done) begin
         irq_flag <= 1'b1;
      end else if (flag_clr) begin
         irq_flag <= 1'b0;
      end
   end

   assign irq = irq_flag && irq_en;

   // read port
   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(rd_addr))
         REG_CTRL:   rd_data = DATA_W'({post_q, on_q, pre_q});
         REG_COUNT:  rd_data = DATA_W'(count);
         REG_PERIOD: rd_data = DATA_W'(period_q);
         default:    rd_data = '0;
      endcase
   end

   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_q && !wr_en) |=> ($stable(count) && !match_pulse)); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag); // R5
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      post_done |=> irq_flag); // R5
   AST_PULSE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> (count == '0 || $past(wr_cnt) || $past(adv))); // R3

endmodule

// File: tb/period_timer_test.sv
module period_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       flag_clr = 1'b0;
   logic       irq_en = 1'b0;
   logic       match_pulse, irq_flag, irq;

   int n_run = 0;
   int n_fail = 0;
   int mcount = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   period_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .flag_clr(flag_clr), .irq_en(irq_en),
      .match_pulse(match_pulse), .irq_flag(irq_flag), .irq(irq)
   );

   always @(negedge clk) if (rst_n && match_pulse) mcount++;

   typedef struct packed {
      logic [1:0]  pre;
      logic [3:0]  post;
      logic [7:0]  per;
      logic [15:0] n;
      logic [7:0]  m;
      logic        f;
   } vec_t;

   // expected matches = n / (prescale * (period+1)); flag = matches >= post+1
   localparam vec_t VECS [8] = '{
      '{2'd0, 4'd0,  8'd4, 16'd20,  8'd4,  1'b1},
      '{2'd1, 4'd2,  8'd2, 16'd40,  8'd3,  1'b1},
      '{2'd2, 4'd0,  8'd1, 16'd31,  8'd0,  1'b0},
      '{2'd3, 4'd1,  8'd0, 16'd48,  8'd3,  1'b1},
      '{2'd0, 4'd15, 8'd3, 16'd60,  8'd15, 1'b0},
      '{2'd0, 4'd15, 8'd3, 16'd64,  8'd16, 1'b1},
      '{2'd1, 4'd4,  8'd9, 16'd199, 8'd4,  1'b0},
      '{2'd2, 4'd0,  8'd1, 16'd32,  8'd1,  1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   function automatic logic [7:0] ctrl(input logic [1:0] pre, input logic on, input logic [3:0] post);
      return {1'b0, post, on, pre};
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk("R1 control", v, 0);
      rd(2'd1, v); chk("R1 counter", v, 0);
      rd(2'd2, v); chk("R1 period", v, 255);
      chk("R1 flag", int'(irq_flag), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 match", int'(match_pulse), 0);

      // R10 reserved bit and unused address
      wr(2'd0, 8'hFF);
      rd(2'd0, v); chk("R10 bit7 reads 0", v, 8'h7F);
      rd(2'd3, v); chk("R10 addr3 zero", v, 0);
      wr(2'd0, 8'h00);

      // Table walk: R2, R3, R4
      for (int i = 0; i < 8; i++) begin
         clear_flag();
         wr(2'd2, VECS[i].per);
         wr(2'd0, ctrl(VECS[i].pre, 1'b1, VECS[i].post));
         wr(2'd1, 8'd0);
         mcount = 0;
         ticks(int'(VECS[i].n));
         chk($sformatf("R2 R3 vector %0d matches", i), mcount, int'(VECS[i].m));
         chk($sformatf("R4 vector %0d flag", i), int'(irq_flag), int'(VECS[i].f));
      end

      // R7 run bit off: ticks ignored
      wr(2'd0, ctrl(2'd0, 1'b0, 4'd0));
      wr(2'd2, 8'd3);
      wr(2'd1, 8'd3);
      mcount = 0;
      ticks(10);
      rd(2'd1, v); chk("R7 counter holds", v, 3);
      chk("R7 no match", mcount, 0);

      // R9 period write keeps counter
      wr(2'd2, 8'h20);
      rd(2'd1, v); chk("R9 counter kept", v, 3);
      rd(2'd2, v); chk("R9 period written", v, 8'h20);

      // R3 counter value and wrap
      wr(2'd2, 8'd200);
      wr(2'd0, ctrl(2'd0, 1'b1, 4'd0));
      wr(2'd1, 8'd0);
      ticks(7);
      rd(2'd1, v); chk("R3 counter after 7", v, 7);
      wr(2'd2, 8'd10);
      wr(2'd1, 8'd10);
      mcount = 0;
      ticks(1);
      rd(2'd1, v); chk("R3 wrap to zero", v, 0);
      chk("R3 single match", mcount, 1);

      // R8 write and tick in the same cycle: write wins
      wr(2'd2, 8'd200);
      tick = 1'b1;
      wr(2'd1, 8'd3);
      tick = 1'b0;
      rd(2'd1, v); chk("R8 write beats tick", v, 3);

      // R8 control write clears prescaler
      wr(2'd2, 8'd0);
      wr(2'd0, ctrl(2'd1, 1'b1, 4'd0));
      wr(2'd1, 8'd0);
      mcount = 0;
      ticks(3);
      wr(2'd0, ctrl(2'd1, 1'b1, 4'd0));
      ticks(3);
      chk("R8 prescaler restarted", mcount, 0);
      ticks(1);
      chk("R8 prescaler fourth tick", mcount, 1);

      // R8 counter write clears postscaler (ratio 2)
      wr(2'd0, ctrl(2'd0, 1'b1, 4'd1));
      wr(2'd1, 8'd0);
      clear_flag();
      ticks(1);
      chk("R8 first match no flag", int'(irq_flag), 0);
      wr(2'd1, 8'd0);
      ticks(1);
      chk("R8 postscaler restarted", int'(irq_flag), 0);
      ticks(1);
      chk("R4 second match sets flag", int'(irq_flag), 1);

      // R6 gating
      irq_en = 1'b0; #1;
      chk("R6 irq masked", int'(irq), 0);
      irq_en = 1'b1; #1;
      chk("R6 irq raised", int'(irq), 1);

      // R5 clear
      clear_flag();
      chk("R5 flag cleared", int'(irq_flag), 0);
      chk("R6 irq follows flag", int'(irq), 0);

      // R5 set and clear in the same cycle: set wins
      wr(2'd0, ctrl(2'd0, 1'b1, 4'd0));
      wr(2'd1, 8'd0);
      tick = 1'b1; flag_clr = 1'b1;
      @(negedge clk);
      tick = 1'b0; flag_clr = 1'b0;
      chk("R5 set beats clear", int'(irq_flag), 1);
      clear_flag();
      chk("R5 clear alone", int'(irq_flag), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule